// File: doc/BRIEF.md
# Saturating Arithmetic Unit

This unit is a combinational saturating datapath for 32-bit words, with one registered sticky saturation flag. Each cycle a 4-bit opcode selects one operation on operand `a_i` and, for add and subtract, operand `b_i`. The operations are:

- signed and unsigned add and subtract
- signed doubling
- clamping a word to a programmable bit position, signed or unsigned
- the same clamping applied to each 16-bit half of the word on its own

The result appears on `result_o` in the same cycle.

When the selected operation clips its result, the flag `sat_o` is set at the next rising clock edge. It then stays set until `clear_i` is asserted, so software or a sequencer can run a batch of operations and check once whether any of them saturated. A clear overrides a set that happens in the same cycle.

Top module: `sat_alu`

## Requirements
- R1: Opcode 1 (signed add) returns a+b. When both operands share a sign and the wrapped sum's sign differs from a's, it returns 0x7FFFFFFF if a is non-negative and 0x80000000 otherwise, and counts as clipping.
- R2: Opcode 2 (signed subtract) returns a−b. When the operands differ in sign and the wrapped difference's sign differs from a's, it clamps as in R1 and counts as clipping.
- R3: Opcode 3 (unsigned add) returns a+b, or 0xFFFFFFFF with clipping when the true sum exceeds 32 bits.
- R4: Opcode 4 (unsigned subtract) returns a−b, or 0 with clipping when b > a.
- R5: Opcode 5 (doubling) returns 0x7FFFFFFF for signed a ≥ 0x40000000 and 0x80000000 for signed a ≤ 0xC0000000, both counting as clipping. Any other a returns a shifted left by one.
- R6: Opcode 6 clamps signed a to the range −2^N … 2^N−1, where N = `shift_i` (0..31), and clips when a lies outside that range.
- R7: Opcode 7 clamps signed a to 0 … 2^N−1 and clips when a lies outside that range.
- R8: Opcodes 8 (signed) and 9 (unsigned) sign-extend bits 15:0 and bits 31:16 separately. They clamp each half as in R6 or R7 with the same N, put the low 16 bits of the low result in 15:0 and the low 16 bits of the high result in 31:16, and clip when either half clips.
- R9: A clipping operation sets `sat_o` at the next rising edge. A non-clipping operation never clears it.
- R10: `clear_i` high forces `sat_o` to 0 at the next edge, even when a clipping operation is applied in the same cycle.
- R11: Opcodes 0 and 10..15 return 0 and leave `sat_o` unchanged.
- R12: `rst_ni` low clears `sat_o` asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation select |
| a_i | input | 32 | First operand, or the value to clamp |
| b_i | input | 32 | Second operand for add and subtract |
| shift_i | input | 5 | Clamp bit position N |
| clear_i | input | 1 | Clears the sticky flag |
| result_o | output | 32 | Operation result (combinational) |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The bench drives every pair from a set of 16 edge values through add and subtract. It sweeps every N from 0 to 31 against those values for all four clamp opcodes, and compares each result with wide integer arithmetic.

Each of the following errors would show up as a wrong value or a wrong flag:

- Off-by-one clamp thresholds would pass 2^N or −2^N−1 unclipped.
- Halves that are not separated would let a clip in the low half leak into the upper bits.
- A doubling rule written as a plain overflow test would miss the flag at exactly 0xC0000000.
- A sticky flag cleared by ordinary operations, or a clear that loses to a simultaneous set, would show the wrong `sat_o` after the edge.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int DW = 32;
  localparam int HW = DW / 2;
  localparam int SW = $clog2(DW);

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_SADD  = 4'd1,
    OP_SSUB  = 4'd2,
    OP_UADD  = 4'd3,
    OP_USUB  = 4'd4,
    OP_SDBL  = 4'd5,
    OP_SCLMP = 4'd6,
    OP_UCLMP = 4'd7,
    OP_SCLM2 = 4'd8,
    OP_UCLM2 = 4'd9
  } sat_op_e;
endpackage

// File: rtl/sat_clip.sv
module sat_clip import sat_pkg::*; (
  input  logic [DW-1:0] val_i,
  input  logic [SW-1:0] shift_i,
  input  logic          uns_i,
  output logic [DW-1:0] res_o,
  output logic          clip_o
);
  logic signed [DW-1:0] top;
  logic        [DW-1:0] mask;

  assign top  = $signed(val_i) >>> shift_i;
  assign mask = (DW'(1) << shift_i) - DW'(1);

  always_comb begin
    res_o  = val_i;
    clip_o = 1'b0;
    if (uns_i) begin
      if (val_i[DW-1]) begin
        res_o  = '0;
        clip_o = 1'b1;
      end else if (val_i > mask) begin
        res_o  = mask;
        clip_o = 1'b1;
      end
    end else begin
      if (top > 0) begin
        res_o  = mask;
        clip_o = 1'b1;
      end else if (top < -1) begin
        res_o  = ~mask;
        clip_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_lanes.sv
module sat_lanes import sat_pkg::*; (
  input  sat_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [SW-1:0] shift_i,
  output logic [DW-1:0] res_o,
  output logic          clip_o
);
  localparam int NLANE = 3;  // full word, low half, high half

  logic [DW-1:0]    lane_in  [NLANE];
  logic [DW-1:0]    lane_res [NLANE];
  logic [NLANE-1:0] lane_clip;
  logic uns, word, dual;

  assign uns  = (op_i == OP_UCLMP) || (op_i == OP_UCLM2);
  assign word = (op_i == OP_SCLMP) || (op_i == OP_UCLMP);
  assign dual = (op_i == OP_SCLM2) || (op_i == OP_UCLM2);

  assign lane_in[0] = a_i;
  assign lane_in[1] = {{HW{a_i[HW-1]}}, a_i[HW-1:0]};
  assign lane_in[2] = {{HW{a_i[DW-1]}}, a_i[DW-1:HW]};

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    sat_clip u_clip (
      .val_i  (lane_in[g]),
      .shift_i(shift_i),
      .uns_i  (uns),
      .res_o  (lane_res[g]),
      .clip_o (lane_clip[g])
    );
  end

  always_comb begin
    res_o  = '0;
    clip_o = 1'b0;
    if (word) begin
      res_o  = lane_res[0];
      clip_o = lane_clip[0];
    end else if (dual) begin
      res_o  = {lane_res[2][HW-1:0], lane_res[1][HW-1:0]};
      clip_o = lane_clip[2] | lane_clip[1];
    end
  end
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub import sat_pkg::*; (
  input  sat_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o,
  output logic          clip_o
);
  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_MAX = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] DBL_HI  = {2'b01, {(DW-2){1'b0}}};
  localparam logic [DW-1:0] DBL_LO  = {2'b11, {(DW-2){1'b0}}};

  logic [DW-1:0] sum, dif, lim;
  logic [DW:0]   usum;
  logic          s_ovf, d_ovf, dbl_hi, dbl_lo;

  assign sum    = a_i + b_i;
  assign dif    = a_i - b_i;
  assign usum   = {1'b0, a_i} + {1'b0, b_i};
  assign lim    = a_i[DW-1] ? NEG_MAX : POS_MAX;
  assign s_ovf  = (a_i[DW-1] == b_i[DW-1]) && (sum[DW-1] != a_i[DW-1]);
  assign d_ovf  = (a_i[DW-1] != b_i[DW-1]) && (dif[DW-1] != a_i[DW-1]);
  assign dbl_hi = $signed(a_i) >= $signed(DBL_HI);
  assign dbl_lo = $signed(a_i) <= $signed(DBL_LO);

  always_comb begin
    res_o  = '0;
    clip_o = 1'b0;
    unique case (op_i)
      OP_SADD: begin res_o = s_ovf ? lim : sum; clip_o = s_ovf; end
      OP_SSUB: begin res_o = d_ovf ? lim : dif; clip_o = d_ovf; end
      OP_UADD: begin res_o = usum[DW] ? '1 : usum[DW-1:0]; clip_o = usum[DW]; end
      OP_USUB: begin res_o = (b_i > a_i) ? '0 : dif; clip_o = b_i > a_i; end
      OP_SDBL: begin
        clip_o = dbl_hi | dbl_lo;
        res_o  = dbl_hi ? POS_MAX : dbl_lo ? NEG_MAX : {a_i[DW-2:0], 1'b0};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu import sat_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [SW-1:0] shift_i,
  input  logic          clear_i,
  output logic [DW-1:0] result_o,
  output logic          sat_o
);
  sat_op_e       op;
  logic [DW-1:0] as_res, ln_res;
  logic          as_clip, ln_clip, clip;

  assign op = sat_op_e'(op_i);

  sat_addsub u_addsub (
    .op_i(op), .a_i(a_i), .b_i(b_i), .res_o(as_res), .clip_o(as_clip)
  );

  sat_lanes u_lanes (
    .op_i(op), .a_i(a_i), .shift_i(shift_i), .res_o(ln_res), .clip_o(ln_clip)
  );

  // each unit drives zero outside its own opcodes
  assign result_o = as_res | ln_res;
  assign clip     = as_clip | ln_clip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sat_o <= 1'b0;
    else if (clear_i) sat_o <= 1'b0;
    else if (clip)    sat_o <= 1'b1;
  end

  // R1: same-sign operands never give a result of the other sign
  p_sadd_sign_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd1 && a_i[DW-1] == b_i[DW-1]) |-> result_o[DW-1] == a_i[DW-1]);
  // R3: unsigned add never drops below the first operand
  p_uadd_mono_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd3) |-> result_o >= a_i);
  // R4: unsigned subtract never exceeds the first operand
  p_usub_mono_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd4) |-> result_o <= a_i);
  // R9: the flag is set after a clip and held until cleared
  p_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clip && !clear_i) |=> sat_o);
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o && !clear_i) |=> sat_o);
  // R10: clear wins over a clip in the same cycle
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !sat_o);
  // R11: unused codes give zero and leave the flag alone
  p_unused_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd0 || op_i > 4'd9) |-> result_o == '0);
  p_unused_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == 4'd0 || op_i > 4'd9) && !clear_i) |=> $stable(sat_o));
endmodule

// File: tb/tb_sat_alu.sv
module tb_sat_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [4:0]  shift_i = '0;
  logic        clear_i = 1'b0;
  logic [31:0] result_o;
  logic        sat_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  sat_alu dut (.*);

  logic [31:0] edges [16] = '{32'h0, 32'h1, 32'h2, 32'h7FFFFFFF, 32'h80000000,
    32'h80000001, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h40000000, 32'h3FFFFFFF,
    32'hC0000000, 32'hC0000001, 32'h00007FFF, 32'hFFFF8000, 32'h12345678,
    32'h00018000};

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void clamp32(input longint s, output logic [31:0] r, output bit c);
    if (s > 64'sd2147483647)       begin r = 32'h7FFFFFFF; c = 1; end
    else if (s < -64'sd2147483648) begin r = 32'h80000000; c = 1; end
    else                           begin r = s[31:0];      c = 0; end
  endfunction

  function automatic void ssat_ref(input longint v, input int n,
                                   output logic [31:0] r, output bit c);
    longint hi, lo;
    hi = (longint'(1) <<< n) - 1;
    lo = -(longint'(1) <<< n);
    if (v > hi)      begin r = hi[31:0]; c = 1; end
    else if (v < lo) begin r = lo[31:0]; c = 1; end
    else             begin r = v[31:0];  c = 0; end
  endfunction

  function automatic void usat_ref(input longint v, input int n,
                                   output logic [31:0] r, output bit c);
    longint hi;
    hi = (longint'(1) <<< n) - 1;
    if (v < 0)       begin r = '0;       c = 1; end
    else if (v > hi) begin r = hi[31:0]; c = 1; end
    else             begin r = v[31:0];  c = 0; end
  endfunction

  function automatic void ref_model(input logic [3:0] op, input logic [31:0] a, b,
                                    input int n, output logic [31:0] r, output bit c);
    longint sa, sb, lo_v, hi_v, u;
    logic [31:0] rl, rh;
    bit cl, ch;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    lo_v = longint'($signed(a[15:0]));
    hi_v = longint'($signed(a[31:16]));
    r = '0; c = 0;
    case (op)
      4'd1: clamp32(sa + sb, r, c);
      4'd2: clamp32(sa - sb, r, c);
      4'd3: begin
        u = longint'(a) + longint'(b);
        if (u > 64'sh0FFFFFFFF) begin r = '1; c = 1; end else r = u[31:0];
      end
      4'd4: if (b > a) begin r = '0; c = 1; end else r = a - b;
      4'd5: begin
        if (sa >= 64'sd1073741824)       begin r = 32'h7FFFFFFF; c = 1; end
        else if (sa <= -64'sd1073741824) begin r = 32'h80000000; c = 1; end
        else r = a << 1;
      end
      4'd6: ssat_ref(sa, n, r, c);
      4'd7: usat_ref(sa, n, r, c);
      4'd8, 4'd9: begin
        if (op == 4'd8) begin ssat_ref(lo_v, n, rl, cl); ssat_ref(hi_v, n, rh, ch); end
        else            begin usat_ref(lo_v, n, rl, cl); usat_ref(hi_v, n, rh, ch); end
        r = {rh[15:0], rl[15:0]};
        c = cl | ch;
      end
      default: ;
    endcase
  endfunction

  // clear + op in one cycle (clear must win), then op alone (flag follows the clip)
  task automatic run_op(input logic [3:0] op, input logic [31:0] a, b,
                        input int n, input string req);
    logic [31:0] er;
    bit ec;
    ref_model(op, a, b, n, er, ec);
    @(negedge clk_i);
    clear_i = 1'b1; op_i = op; a_i = a; b_i = b; shift_i = 5'(n);
    @(negedge clk_i);
    check(sat_o == 1'b0, "R10 clear over clip", {31'b0, sat_o}, 32'h0);
    clear_i = 1'b0;
    #1 check(result_o == er, req, result_o, er);
    @(negedge clk_i);
    check(sat_o == ec, "R9 flag after op", {31'b0, sat_o}, {31'b0, ec});
  endtask

  task automatic step(input logic [3:0] op, input logic [31:0] a, b, input logic clr);
    @(negedge clk_i);
    clear_i = clr; op_i = op; a_i = a; b_i = b; shift_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #23;
    check(sat_o == 1'b0, "R12 reset", {31'b0, sat_o}, 32'h0);
    rst_ni = 1'b1;

    foreach (edges[i]) foreach (edges[j]) begin
      run_op(4'd1, edges[i], edges[j], 0, "R1 signed add");
      run_op(4'd2, edges[i], edges[j], 0, "R2 signed sub");
      run_op(4'd3, edges[i], edges[j], 0, "R3 unsigned add");
      run_op(4'd4, edges[i], edges[j], 0, "R4 unsigned sub");
    end
    foreach (edges[i]) run_op(4'd5, edges[i], 32'h0, 0, "R5 doubling");

    for (int n = 0; n < 32; n++) begin
      foreach (edges[i]) begin
        run_op(4'd6, edges[i], 32'h0, n, "R6 signed clamp");
        run_op(4'd7, edges[i], 32'h0, n, "R7 unsigned clamp");
        run_op(4'd8, edges[i], 32'h0, n, "R8 dual signed clamp");
        run_op(4'd9, edges[i], 32'h0, n, "R8 dual unsigned clamp");
      end
      run_op(4'd6, 32'h1 << n, 32'h0, n, "R6 just above range");
      run_op(4'd6, 32'hFFFFFFFF << n, 32'h0, n, "R6 at lower bound");
      run_op(4'd7, (32'h1 << n) - 1, 32'h0, n, "R7 at upper bound");
    end

    // R11: unused codes with flag clear stay clear and give zero
    step(4'd0, 32'h0, 32'h0, 1'b1);
    for (int op = 10; op < 16; op++) begin
      step(4'(op), 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0);
      #1 check(result_o == 32'h0, "R11 unused result", result_o, 32'h0);
      @(negedge clk_i);
      check(sat_o == 1'b0, "R11 unused flag low", {31'b0, sat_o}, 32'h0);
    end

    // R9: sticky through non-clipping ops
    step(4'd1, 32'h7FFFFFFF, 32'h1, 1'b0);
    step(4'd4, 32'h5, 32'h3, 1'b0);
    step(4'd0, 32'h0, 32'h0, 1'b0);
    check(sat_o == 1'b1, "R9 sticky", {31'b0, sat_o}, 32'h1);

    // R11: unused codes with flag set keep it set
    for (int op = 10; op < 16; op++) begin
      step(4'(op), 32'h0, 32'h0, 1'b0);
      #1 check(result_o == 32'h0, "R11 unused result", result_o, 32'h0);
      @(negedge clk_i);
      check(sat_o == 1'b1, "R11 unused flag high", {31'b0, sat_o}, 32'h1);
    end

    // R10: clear alone
    step(4'd0, 32'h0, 32'h0, 1'b1);
    step(4'd0, 32'h0, 32'h0, 1'b0);
    check(sat_o == 1'b0, "R10 clear", {31'b0, sat_o}, 32'h0);

    // R12: asynchronous reset drops a set flag
    step(4'd3, 32'hFFFFFFFF, 32'h1, 1'b0);
    step(4'd0, 32'h0, 32'h0, 1'b0);
    check(sat_o == 1'b1, "R9 set before reset", {31'b0, sat_o}, 32'h1);
    #2 rst_ni = 1'b0;
    #1 check(sat_o == 1'b0, "R12 async reset", {31'b0, sat_o}, 32'h0);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule